// File: doc/BRIEF.md
# LIN Dynamic Identifier Command Mapper

This block sits behind the frame receiver of a LIN slave node. It keeps a small table that links each 4-bit command pointer to a 6-bit bus identifier chosen by the master at run time. It then uses that table to tell the command layer which application command an incoming frame carries. The receiver hands over every frame that passed its parity and checksum tests as a single-cycle strobe. The strobe carries the 6-bit identifier and the eight data bytes, with data byte n on bits [8n-1:8n-8].

The master fills the table with assignment frames on the reserved command identifier. Each such frame carries four bit-packed identifier/pointer pairs, and it applies either to every node or only to the node whose physical address it names. Every frame produces one lookup result on the following cycle. The block also remembers whether the previous frame was a preparing frame addressed to this node, and uses that to accept or ignore a read on the indirect identifier. The node's 7-bit physical address is built inside the block from four programmable bits and three hardwired bits.

Top module: `lin_dynid_mapper`

## Requirements
- R1: After reset every table entry is invalid, so no identifier hits. `lookupStb`, `lookupHit`, `lookupPtr` and `readOk` are all 0, and no preparation is pending.
- R2: A frame is an assignment frame when its identifier is 0x3C, data byte 1 is 0x80 and data byte 2 is 0x91 (a 1 followed by command 0x11). A 0x3C frame that fails either byte test writes nothing.
- R3: Data byte 3 of an assignment frame gates the write. When bit 7 is 0 the write applies to every node. When bit 7 is 1 the write applies only if bits 6:0 equal `nodeAddr`.
- R4: The four (identifier, pointer) pairs are unpacked as follows. Pair 1 has pointer = byte4[3:0] and id = {byte5[1:0], byte4[7:4]}. Pair 2 has pointer = byte5[5:2] and id = {byte6[3:0], byte5[7:6]}. Pair 3 has pointer = byte6[7:4] and id = byte7[5:0]. Pair 4 has pointer = {byte8[1:0], byte7[7:6]} and id = byte8[7:2]. Each pair sets its pointer's entry valid with that id.
- R5: A pair whose pointer is NumPtr (default 9) or higher is dropped. A hit never reports a pointer at or above NumPtr.
- R6: One cycle after each frame strobe, `lookupStb` pulses for one cycle. `lookupHit` shows whether a valid entry holds the frame's identifier and `lookupPtr` gives that entry's pointer. On a miss `lookupPtr` is 0. Lookups use the table contents from before the frame.
- R7: When several valid entries hold the same identifier, the lowest pointer is reported.
- R8: Identifiers 0x3C to 0x3F never produce a hit.
- R9: With `addrMode`=0, `nodeAddr` = {pa[3:0], hw[2:0]}. With `addrMode`=1, `nodeAddr` = {hw[2], pa[3:0], hw[1:0]}.
- R10: A frame is a preparing frame for this node when its identifier hits pointer 8 (PrepPtr), data byte 2 bit 7 is 1, and byte 2 bits 6:0 equal `nodeAddr`. Such a frame makes a preparation pending.
- R11: A frame with identifier 0x3D raises `readOk` for one cycle, at the same time as its `lookupStb`, only when a preparation was pending. Otherwise `readOk` stays 0.
- R12: Every frame that is not a preparing frame for this node clears the pending preparation. This includes a 0x3D frame and a preparing frame for another address.
- R13: A later write to a pointer replaces its identifier. Within one frame, a later pair wins over an earlier pair that names the same pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | One-cycle strobe for a validated frame |
| frameId | input | 6 | Frame identifier without parity bits |
| frameData | input | 64 | Data bytes; byte n on [8n-1:8n-8] |
| pa | input | 4 | Programmable address bits |
| hw | input | 3 | Hardwired address bits |
| addrMode | input | 1 | Selects the address bit arrangement |
| nodeAddr | output | 7 | Composed physical address |
| lookupStb | output | 1 | One-cycle lookup result strobe |
| lookupHit | output | 1 | Identifier found in table |
| lookupPtr | output | 4 | Matched command pointer |
| readOk | output | 1 | Indirect read accepted |

## Verification
The hardest case to reach is the decision on an indirect read. It depends on state left by the previous frame, and that state is only visible through a later 0x3D frame. The stimulus first assigns a dynamic identifier to the preparing pointer through a broadcast assignment frame. It then sends preparing frames with the right address, the wrong address and a cleared byte-2 bit 7, and follows each with a 0x3D frame. Other sequences put an unrelated frame between the preparation and the read, send two reads in a row, and repeat the test after switching the address mode. The bit-packed pairs are checked through lookups, with identifier values chosen so that the bits that cross byte boundaries differ from the neighbouring fields.

// File: rtl/lin_dynid_pkg.sv
package lin_dynid_pkg;
  localparam int IdW           = 6;
  localparam int PtrW          = 4;
  localparam int AddrW         = 7;
  localparam int NumBytes      = 8;
  localparam int PairsPerFrame = 4;

  localparam logic [IdW-1:0] AssignId      = 6'h3C;
  localparam logic [IdW-1:0] IndirectId    = 6'h3D;
  localparam logic [7:0]     AppCmdByte    = 8'h80;
  localparam logic [7:0]     AssignCmdByte = 8'h91;

  typedef struct packed {
    logic tblWrite;
    logic lookupEn;
  } ctrlStb_t;

  typedef struct packed {
    logic [IdW-1:0]  id;
    logic [PtrW-1:0] ptr;
  } idPair_t;
endpackage

// File: rtl/lin_dynid_datapath.sv
module lin_dynid_datapath
  import lin_dynid_pkg::*;
#(
  parameter int NumPtr = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStb_t             stb,
  input  logic [IdW-1:0]       frameId,
  input  logic [39:0]          pairBytes,
  input  logic [3:0]           pa,
  input  logic [2:0]           hw,
  input  logic                 addrMode,
  output logic [AddrW-1:0]     nodeAddr,
  output logic                 matchHit,
  output logic [PtrW-1:0]      matchPtr
);
  logic [7:0] b4, b5, b6, b7, b8;
  idPair_t    pairs [PairsPerFrame];
  logic [NumPtr-1:0] tblValid;
  logic [IdW-1:0]    tblId [NumPtr];

  assign b4 = pairBytes[7:0];
  assign b5 = pairBytes[15:8];
  assign b6 = pairBytes[23:16];
  assign b7 = pairBytes[31:24];
  assign b8 = pairBytes[39:32];

  // Unpack the four pairs; fields cross byte boundaries.
  always_comb begin
    pairs[0].ptr = b4[3:0];
    pairs[0].id  = {b5[1:0], b4[7:4]};
    pairs[1].ptr = b5[5:2];
    pairs[1].id  = {b6[3:0], b5[7:6]};
    pairs[2].ptr = b6[7:4];
    pairs[2].id  = b7[5:0];
    pairs[3].ptr = {b8[1:0], b7[7:6]};
    pairs[3].id  = b8[7:2];
  end

  // Physical address arrangement.
  always_comb begin
    if (addrMode) nodeAddr = {hw[2], pa, hw[1:0]};
    else          nodeAddr = {pa, hw};
  end

  // Table entries, one per pointer; a later pair overrides an earlier one.
  for (genvar e = 0; e < NumPtr; e++) begin : gEntry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tblValid[e] <= 1'b0;
        tblId[e]    <= '0;
      end else if (stb.tblWrite) begin
        for (int k = 0; k < PairsPerFrame; k++) begin
          if (pairs[k].ptr == PtrW'(e)) begin
            tblValid[e] <= 1'b1;
            tblId[e]    <= pairs[k].id;
          end
        end
      end
    end
  end

  // Priority search: scanning downward leaves the lowest pointer.
  always_comb begin
    matchHit = 1'b0;
    matchPtr = '0;
    for (int e = NumPtr - 1; e >= 0; e--) begin
      if (stb.lookupEn && tblValid[e] && (tblId[e] == frameId)) begin
        matchHit = 1'b1;
        matchPtr = PtrW'(e);
      end
    end
  end
endmodule

// File: rtl/lin_dynid_ctrl.sv
module lin_dynid_ctrl
  import lin_dynid_pkg::*;
#(
  parameter int PrepPtr = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameValid,
  input  logic [IdW-1:0]    frameId,
  input  logic [23:0]       hdrBytes,
  input  logic [AddrW-1:0]  nodeAddr,
  input  logic              matchHit,
  input  logic [PtrW-1:0]   matchPtr,
  output ctrlStb_t          stb,
  output logic              lookupStb,
  output logic              lookupHit,
  output logic [PtrW-1:0]   lookupPtr,
  output logic              readOk
);
  logic [7:0] byte1, byte2, byte3;
  logic reservedId, isAssign, addrOk, isPrep, pendingPrep;

  assign byte1 = hdrBytes[7:0];
  assign byte2 = hdrBytes[15:8];
  assign byte3 = hdrBytes[23:16];

  always_comb begin
    reservedId   = (frameId[5:2] == 4'hF);
    isAssign     = frameValid && (frameId == AssignId) &&
                   (byte1 == AppCmdByte) && (byte2 == AssignCmdByte);
    addrOk       = !byte3[7] || (byte3[6:0] == nodeAddr);
    stb.tblWrite = isAssign && addrOk;
    stb.lookupEn = frameValid && !reservedId;
    isPrep       = matchHit && (matchPtr == PtrW'(PrepPtr)) &&
                   byte2[7] && (byte2[6:0] == nodeAddr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendingPrep <= 1'b0;
      lookupStb   <= 1'b0;
      lookupHit   <= 1'b0;
      lookupPtr   <= '0;
      readOk      <= 1'b0;
    end else begin
      lookupStb <= frameValid;
      readOk    <= frameValid && (frameId == IndirectId) && pendingPrep;
      if (frameValid) begin
        pendingPrep <= isPrep;
        lookupHit   <= matchHit;
        lookupPtr   <= matchPtr;
      end else begin
        lookupHit   <= 1'b0;
        lookupPtr   <= '0;
      end
    end
  end
endmodule

// File: rtl/lin_dynid_mapper.sv
module lin_dynid_mapper
  import lin_dynid_pkg::*;
#(
  parameter int NumPtr  = 9,
  parameter int PrepPtr = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frameValid,
  input  logic [IdW-1:0]          frameId,
  input  logic [NumBytes*8-1:0]   frameData,
  input  logic [3:0]              pa,
  input  logic [2:0]              hw,
  input  logic                    addrMode,
  output logic [AddrW-1:0]        nodeAddr,
  output logic                    lookupStb,
  output logic                    lookupHit,
  output logic [PtrW-1:0]         lookupPtr,
  output logic                    readOk
);
  ctrlStb_t        stb;
  logic            matchHit;
  logic [PtrW-1:0] matchPtr;

  lin_dynid_datapath #(.NumPtr(NumPtr)) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .frameId(frameId),
    .pairBytes(frameData[63:24]), .pa(pa), .hw(hw), .addrMode(addrMode),
    .nodeAddr(nodeAddr), .matchHit(matchHit), .matchPtr(matchPtr)
  );

  lin_dynid_ctrl #(.PrepPtr(PrepPtr)) uCtrl (
    .clk(clk), .rst_n(rst_n), .frameValid(frameValid), .frameId(frameId),
    .hdrBytes(frameData[23:0]), .nodeAddr(nodeAddr), .matchHit(matchHit),
    .matchPtr(matchPtr), .stb(stb), .lookupStb(lookupStb),
    .lookupHit(lookupHit), .lookupPtr(lookupPtr), .readOk(readOk)
  );
endmodule

// File: rtl/lin_dynid_checker.sv
module lin_dynid_checker #(
  parameter int NumPtr = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frameValid,
  input logic [5:0] frameId,
  input logic [2:0] hw,
  input logic [6:0] nodeAddr,
  input logic       lookupStb,
  input logic       lookupHit,
  input logic [3:0] lookupPtr,
  input logic       readOk
);
  a_r6_stb_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frameValid |=> lookupStb);
  a_r6_no_spurious_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !frameValid |=> !lookupStb);
  a_r6_miss_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupHit |-> lookupPtr == 4'd0);
  a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    lookupHit |-> int'(lookupPtr) < NumPtr);
  a_r8_reserved_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (frameValid && frameId[5:2] == 4'hF) |=> !lookupHit);
  a_r11_read_only_indirect: assert property (@(posedge clk) disable iff (!rst_n)
    (frameValid && frameId != 6'h3D) |=> !readOk);
  a_r11_read_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    readOk |-> lookupStb);
  a_r9_low_addr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    nodeAddr[1:0] == hw[1:0]);
endmodule

bind lin_dynid_mapper lin_dynid_checker #(.NumPtr(NumPtr)) uChk (
  .clk(clk), .rst_n(rst_n), .frameValid(frameValid), .frameId(frameId),
  .hw(hw), .nodeAddr(nodeAddr), .lookupStb(lookupStb),
  .lookupHit(lookupHit), .lookupPtr(lookupPtr), .readOk(readOk)
);

// File: tb/tb_lin_dynid_mapper.sv
module tb_lin_dynid_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frameValid = 1'b0;
  logic [5:0]  frameId = '0;
  logic [63:0] frameData = '0;
  logic [3:0]  pa = 4'b1010;
  logic [2:0]  hw = 3'b101;
  logic        addrMode = 1'b0;
  logic [6:0]  nodeAddr;
  logic        lookupStb, lookupHit, readOk;
  logic [3:0]  lookupPtr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic       hit;
    logic [3:0] ptr;
    logic       rd;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  lin_dynid_mapper dut (
    .clk(clk), .rst_n(rst_n), .frameValid(frameValid), .frameId(frameId),
    .frameData(frameData), .pa(pa), .hw(hw), .addrMode(addrMode),
    .nodeAddr(nodeAddr), .lookupStb(lookupStb), .lookupHit(lookupHit),
    .lookupPtr(lookupPtr), .readOk(readOk)
  );

  function automatic logic [63:0] asgData(input logic broad, input logic [6:0] ad,
      input logic [5:0] i1, input logic [3:0] p1, input logic [5:0] i2, input logic [3:0] p2,
      input logic [5:0] i3, input logic [3:0] p3, input logic [5:0] i4, input logic [3:0] p4);
    logic [7:0] b4, b5, b6, b7, b8;
    b4 = {i1[3:0], p1};
    b5 = {i2[1:0], p2, i1[5:4]};
    b6 = {p3, i2[5:2]};
    b7 = {p4[1:0], i3};
    b8 = {i4, p4[3:2]};
    return {b8, b7, b6, b5, b4, broad, ad, 8'h91, 8'h80};
  endfunction

  function automatic logic [63:0] prepData(input logic b7, input logic [6:0] ad);
    return {48'h0, b7, ad, 8'h00};
  endfunction

  task automatic send(input logic [5:0] id, input logic [63:0] data,
                      input logic eHit, input logic [3:0] ePtr, input logic eRd,
                      input string tag);
    expItem_t it;
    @(negedge clk);
    it.hit = eHit; it.ptr = ePtr; it.rd = eRd; it.tag = tag;
    expQ.push_back(it);
    frameId = id; frameData = data; frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  task automatic checkAddr(input logic [6:0] exp, input string tag);
    @(negedge clk);
    checks++;
    if (nodeAddr !== exp) begin
      fails++;
      $display("FAIL %s nodeAddr actual=%h expected=%h", tag, nodeAddr, exp);
    end
  endtask

  // Monitor: pops one expected item per lookup strobe.
  always @(negedge clk) begin
    if (rst_n && lookupStb) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R6 unexpected strobe actual=1 expected=0");
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (lookupHit !== it.hit || lookupPtr !== it.ptr || readOk !== it.rd) begin
          fails++;
          $display("FAIL %s actual hit=%b ptr=%0d rd=%b expected hit=%b ptr=%0d rd=%b",
                   it.tag, lookupHit, lookupPtr, readOk, it.hit, it.ptr, it.rd);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (lookupStb !== 1'b0 || lookupHit !== 1'b0 || lookupPtr !== 4'd0 || readOk !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b%b%h%b expected=0000",
               lookupStb, lookupHit, lookupPtr, readOk);
    end
    checkAddr(7'h55, "R9 mode0");
    send(6'h05, 64'h0, 1'b0, 4'd0, 1'b0, "R1 empty table miss");
    send(6'h3D, 64'h0, 1'b0, 4'd0, 1'b0, "R1 no pending after reset");

    // Broadcast assignment (R2 R3 R4): duplicate id at pointers 3 and 0.
    send(6'h3C, asgData(1'b0, 7'h00, 6'h05, 4'd3, 6'h12, 4'd4, 6'h2A, 4'd8, 6'h05, 4'd0),
         1'b0, 4'd0, 1'b0, "R8 assignment frame itself");
    send(6'h12, 64'h0, 1'b1, 4'd4, 1'b0, "R4 pair2 straddle");
    send(6'h2A, 64'h0, 1'b1, 4'd8, 1'b0, "R4 pair3");
    send(6'h05, 64'h0, 1'b1, 4'd0, 1'b0, "R7 lowest pointer wins");
    send(6'h33, 64'h0, 1'b0, 4'd0, 1'b0, "R6 unknown id miss");

    // R2: bad byte1 / byte2 writes nothing.
    send(6'h3C, asgData(1'b0, 7'h00, 6'h33, 4'd1, 6'h33, 4'd1, 6'h33, 4'd1, 6'h33, 4'd1) ^ 64'h01,
         1'b0, 4'd0, 1'b0, "R2 bad byte1 frame");
    send(6'h3C, asgData(1'b0, 7'h00, 6'h33, 4'd1, 6'h33, 4'd1, 6'h33, 4'd1, 6'h33, 4'd1) ^ 64'h0100,
         1'b0, 4'd0, 1'b0, "R2 bad byte2 frame");
    send(6'h33, 64'h0, 1'b0, 4'd0, 1'b0, "R2 nothing written");

    // R3: addressed write, wrong then right address.
    send(6'h3C, asgData(1'b1, 7'h54, 6'h33, 4'd1, 6'h34, 4'd2, 6'h35, 4'd5, 6'h36, 4'd6),
         1'b0, 4'd0, 1'b0, "R3 addressed other frame");
    send(6'h33, 64'h0, 1'b0, 4'd0, 1'b0, "R3 other address ignored");
    send(6'h3C, asgData(1'b1, 7'h55, 6'h33, 4'd1, 6'h34, 4'd2, 6'h35, 4'd5, 6'h36, 4'd6),
         1'b0, 4'd0, 1'b0, "R3 addressed own frame");
    send(6'h33, 64'h0, 1'b1, 4'd1, 1'b0, "R3 own address pair1");
    send(6'h36, 64'h0, 1'b1, 4'd6, 1'b0, "R4 pair4 straddle");
    send(6'h35, 64'h0, 1'b1, 4'd5, 1'b0, "R4 pair3 pointer");

    // R5 and R13: out-of-range pointers, same-frame duplicate pointer.
    send(6'h3C, asgData(1'b0, 7'h00, 6'h20, 4'd9, 6'h21, 4'd15, 6'h22, 4'd7, 6'h23, 4'd7),
         1'b0, 4'd0, 1'b0, "R5 frame");
    send(6'h20, 64'h0, 1'b0, 4'd0, 1'b0, "R5 pointer 9 dropped");
    send(6'h21, 64'h0, 1'b0, 4'd0, 1'b0, "R5 pointer 15 dropped");
    send(6'h22, 64'h0, 1'b0, 4'd0, 1'b0, "R13 earlier pair replaced");
    send(6'h23, 64'h0, 1'b1, 4'd7, 1'b0, "R13 later pair wins");

    // R13 across frames, R8 reserved id stored but never hits.
    send(6'h3C, asgData(1'b0, 7'h00, 6'h13, 4'd4, 6'h3E, 4'd2, 6'h01, 4'd12, 6'h01, 4'd13),
         1'b0, 4'd0, 1'b0, "R13 rewrite frame");
    send(6'h12, 64'h0, 1'b0, 4'd0, 1'b0, "R13 old id gone");
    send(6'h13, 64'h0, 1'b1, 4'd4, 1'b0, "R13 new id");
    send(6'h3E, 64'h0, 1'b0, 4'd0, 1'b0, "R8 reserved id no hit");
    send(6'h34, 64'h0, 1'b0, 4'd0, 1'b0, "R13 pointer2 replaced");

    // R10 R11 R12: preparation sequences.
    send(6'h2A, prepData(1'b1, 7'h55), 1'b1, 4'd8, 1'b0, "R10 prep own");
    send(6'h3D, 64'h0, 1'b0, 4'd0, 1'b1, "R11 read after prep");
    send(6'h3D, 64'h0, 1'b0, 4'd0, 1'b0, "R12 second read rejected");
    send(6'h2A, prepData(1'b1, 7'h54), 1'b1, 4'd8, 1'b0, "R10 prep other addr");
    send(6'h3D, 64'h0, 1'b0, 4'd0, 1'b0, "R12 read after foreign prep");
    send(6'h2A, prepData(1'b0, 7'h55), 1'b1, 4'd8, 1'b0, "R10 prep bit7 clear");
    send(6'h3D, 64'h0, 1'b0, 4'd0, 1'b0, "R10 read after bad prep");
    send(6'h2A, prepData(1'b1, 7'h55), 1'b1, 4'd8, 1'b0, "R10 prep own again");
    send(6'h13, 64'h0, 1'b1, 4'd4, 1'b0, "R12 intervening frame");
    send(6'h3D, 64'h0, 1'b0, 4'd0, 1'b0, "R12 read after intervening frame");
    send(6'h2A, prepData(1'b1, 7'h55), 1'b1, 4'd8, 1'b0, "R10 prep first");
    send(6'h2A, prepData(1'b1, 7'h55), 1'b1, 4'd8, 1'b0, "R10 prep repeated");
    send(6'h3D, 64'h0, 1'b0, 4'd0, 1'b1, "R11 read after repeated prep");

    // R9: second address arrangement.
    addrMode = 1'b1;
    checkAddr(7'h69, "R9 mode1");
    send(6'h2A, prepData(1'b1, 7'h55), 1'b1, 4'd8, 1'b0, "R9 old address prep");
    send(6'h3D, 64'h0, 1'b0, 4'd0, 1'b0, "R9 old address rejected");
    send(6'h2A, prepData(1'b1, 7'h69), 1'b1, 4'd8, 1'b0, "R9 mode1 prep");
    send(6'h3D, 64'h0, 1'b0, 4'd0, 1'b1, "R9 mode1 read");
    send(6'h3C, asgData(1'b1, 7'h69, 6'h0F, 4'd2, 6'h01, 4'd12, 6'h01, 4'd13, 6'h01, 4'd14),
         1'b0, 4'd0, 1'b0, "R3 mode1 addressed frame");
    send(6'h0F, 64'h0, 1'b1, 4'd2, 1'b0, "R3 mode1 addressed write");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R6 missing strobes actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule